// File: doc/BRIEF.md
# Converter Output Latency and Blanking Pipeline

This block sits between an image-sensor converter core and the 10-bit parallel output bus. It runs on the converter clock. It adds a programmable black pedestal to each raw sample and clips the sum at full scale. It then delays the result by a fixed number of clock edges before the sample reaches the bus. Output coding is straight binary, and bit 9 is the MSB.

An active-low preblank input marks sensor blanking intervals. Each edge tags the sample it captures with the preblank state. The tags travel down a separate, longer delay line. When a set tag reaches the output stage, the bus reads all zeros. As a result, blanking takes effect, and ends, two edges later than ordinary data would. A standby input forces the bus to zero at once, in the same cycle, without waiting for the pipeline.

Top module: `adc_outpipe`

## Requirements
- R1: While reset is asserted, `data_out` is zero. After reset is released, `data_out` stays zero until the first captured sample arrives at the output, which is on the ninth edge.
- R2: With `pblk_n` high, `clamp_code` zero and `standby` low, the sample captured at clock edge n is on `data_out` after edge n+9.
- R3: The value placed on the bus is `sample_in + 4*clamp_code`. The 4-bit code therefore gives a pedestal of 0 to 60 LSB, and code 8 gives 32 LSB.
- R4: When the pedestal sum is larger than 1023, the output is 1023. A sum of exactly 1023 passes through unchanged.
- R5: When `pblk_n` is sampled low at edge n, `data_out` is zero after edge n+11. If `pblk_n` stays low, `data_out` stays zero.
- R6: Suppose `pblk_n` is high on every edge from r onward, after being low at edge r-1. Then `data_out` is zero through edge r+10. From edge r+11 onward, it shows ordinary data, namely the sample captured nine edges earlier.
- R7: A `pblk_n` low level lasting a single edge n blanks exactly one output word, the one after edge n+11. The neighbouring words carry data.
- R8: While `standby` is high, `data_out` is zero in that same cycle. The pipeline keeps advancing. When `standby` falls, the bus shows the same word it would have shown had standby never been asserted.
- R9: The clamp code is taken together with each sample. A code change affects only samples captured on or after the edge at which the new code is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | 10 | Raw converter sample, straight binary |
| pblk_n | input | 1 | Preblank, active low; low tags the captured sample as blanked |
| standby | input | 1 | High forces the output bus to zero immediately |
| clamp_code | input | 4 | Pedestal code, applied as 4 LSB per step |
| data_out | output | 10 | Delayed output word, straight binary |

## Verification
A data word is due nine edges after its sample is captured. A blank tag takes effect eleven edges after the edge that samples `pblk_n` low. Standby acts in the cycle it is applied. The bench records, for every edge index since reset, the sample, code and preblank state it drove. After each rising edge it samples the bus at the following falling edge. It compares the bus with a value computed from those records: zero if the record eleven edges back was blanked, otherwise the clipped pedestal sum from nine edges back, and zero whenever standby is high. Preblank toggles at pseudo-random points as well as in directed pulses, so the exact edges of onset and release are checked on every cycle.

// File: rtl/adc_outpipe_pkg.sv
package adc_outpipe_pkg;

    // Default geometry of the output pipeline
    localparam int unsigned SAMPLE_W   = 10;  // output word width
    localparam int unsigned PCODE_W    = 4;   // pedestal code width
    localparam int unsigned PED_SHIFT  = 2;   // pedestal step = 2**PED_SHIFT LSB
    localparam int unsigned DATA_LAT   = 9;   // edges from capture to bus, data path
    localparam int unsigned BLANK_LAT  = 11;  // edges from capture to bus, blank tag

endpackage

// File: rtl/adc_pedestal_stage.sv
module adc_pedestal_stage #(
    parameter int unsigned DATA_W    = 10,
    parameter int unsigned CODE_W    = 4,
    parameter int unsigned PED_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] sum_o
);

    localparam int unsigned PED_W = CODE_W + PED_SHIFT;
    localparam int unsigned SUM_W = ((PED_W > DATA_W) ? PED_W : DATA_W) + 1;
    localparam logic [SUM_W-1:0] FULL_SCALE = SUM_W'({DATA_W{1'b1}});

    typedef struct packed {
        logic [DATA_W-1:0] sum;
    } ped_state_t;

    ped_state_t st_d, st_q;
    logic [SUM_W-1:0] wide_sum;

    always_comb begin
        st_d     = st_q;
        wide_sum = SUM_W'(sample_i) + (SUM_W'(code_i) << PED_SHIFT);
        if (wide_sum > FULL_SCALE) begin
            st_d.sum = {DATA_W{1'b1}};
        end else begin
            st_d.sum = wide_sum[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o = st_q.sum;

    // R4
    sat_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sum_o >= $past(sample_i)));

    // R3
    ped_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (SUM_W'(sum_o) <= SUM_W'($past(sample_i)) + (SUM_W'($past(code_i)) << PED_SHIFT)));

endmodule

// File: rtl/adc_shift_line.sv
module adc_shift_line #(
    parameter int unsigned WIDTH = 10,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] tail_o
);

    localparam int unsigned FILL_W = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stg;
    } line_state_t;

    line_state_t line_d, line_q;

    always_comb begin
        line_d        = line_q;
        line_d.stg[0] = din_i;
        for (int i = 1; i < int'(DEPTH); i++) begin
            line_d.stg[i] = line_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign tail_o = line_q.stg[DEPTH-1];

    // Edge counter since reset, saturating at the line depth
    logic [FILL_W-1:0] fill_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (fill_q != FILL_MAX) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // R1
    line_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q < FILL_MAX) |-> (tail_o == '0));

endmodule

// File: rtl/adc_outpipe.sv
module adc_outpipe
    import adc_outpipe_pkg::*;
#(
    parameter int unsigned DATA_W     = SAMPLE_W,
    parameter int unsigned CODE_W     = PCODE_W,
    parameter int unsigned STEP_SHIFT = PED_SHIFT,
    parameter int unsigned LAT_DATA   = DATA_LAT,
    parameter int unsigned LAT_BLANK  = BLANK_LAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              pblk_n,
    input  logic              standby,
    input  logic [CODE_W-1:0] clamp_code,
    output logic [DATA_W-1:0] data_out
);

    // Pedestal register is stage one and the output register is the last
    // stage, so the data line holds the stages in between.
    localparam int unsigned DLINE_DEPTH = LAT_DATA - 1;
    localparam int unsigned TLINE_DEPTH = LAT_BLANK;
    localparam int unsigned RUN_W       = $clog2(LAT_BLANK + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LAT_BLANK);

    logic [DATA_W-1:0] ped_sum;
    logic [DATA_W-1:0] data_tail;
    logic [0:0]        tag_in;
    logic [0:0]        tag_tail;

    adc_pedestal_stage #(
        .DATA_W    (DATA_W),
        .CODE_W    (CODE_W),
        .PED_SHIFT (STEP_SHIFT)
    ) u_ped (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_in),
        .code_i   (clamp_code),
        .sum_o    (ped_sum)
    );

    adc_shift_line #(
        .WIDTH (DATA_W),
        .DEPTH (DLINE_DEPTH)
    ) u_data_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (ped_sum),
        .tail_o (data_tail)
    );

    assign tag_in = ~pblk_n;

    adc_shift_line #(
        .WIDTH (1),
        .DEPTH (TLINE_DEPTH)
    ) u_tag_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (tag_in),
        .tail_o (tag_tail)
    );

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (tag_tail[0]) begin
            out_d.word = '0;
        end else begin
            out_d.word = data_tail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_out = standby ? '0 : out_q.word;

    // Run-length counters of the preblank input, used only by the checks
    logic [RUN_W-1:0] lo_run_q;
    logic [RUN_W-1:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run_q <= '0;
            hi_run_q <= '0;
        end else if (!pblk_n) begin
            hi_run_q <= '0;
            if (lo_run_q != RUN_MAX) lo_run_q <= lo_run_q + 1'b1;
        end else begin
            lo_run_q <= '0;
            if (hi_run_q != RUN_MAX) hi_run_q <= hi_run_q + 1'b1;
        end
    end

    // R5
    blank_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_run_q == RUN_MAX) |=> (out_q.word == '0));

    // R5
    blank_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_tail[0] |=> (out_q.word == '0));

    // R6
    release_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run_q == RUN_MAX) |=> (out_q.word == $past(data_tail)));

endmodule

// File: tb/adc_outpipe_bench.sv
module adc_outpipe_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sample_in = '0;
    logic       pblk_n = 1'b1;
    logic       standby = 1'b0;
    logic [3:0] clamp_code = '0;
    logic [9:0] data_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    int samp_h [0:4095];
    int code_h [0:4095];
    bit blk_h  [0:4095];

    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;  // 50 MHz

    adc_outpipe u_adc_outpipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (sample_in),
        .pblk_n     (pblk_n),
        .standby    (standby),
        .clamp_code (clamp_code),
        .data_out   (data_out)
    );

    function automatic int ped_sat(input int s, input int c);
        int v;
        v = s + 4 * c;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    // Expected bus word after edge m (standby not applied)
    function automatic int exp_at(input int m);
        if (m >= 11 && blk_h[m-11]) return 0;
        if (m < 9) return 0;
        return ped_sat(samp_h[m-9], code_h[m-9]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic step(input int s, input bit pb_n, input int c, input bit sb, input string req);
        int e;
        sample_in  = s[9:0];
        pblk_n     = pb_n;
        clamp_code = c[3:0];
        standby    = sb;
        if (cyc < 4096) begin
            samp_h[cyc] = s;
            code_h[cyc] = c;
            blk_h[cyc]  = !pb_n;
        end
        @(posedge clk);
        @(negedge clk);
        e = sb ? 0 : exp_at(cyc);
        chk(req, int'(data_out), e);
        cyc++;
    endtask

    task automatic t_reset();
        sample_in = 10'd500;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in reset", int'(data_out), 0);
        rst_n = 1'b1;
        cyc   = 0;
        for (int i = 0; i < 9; i++) step(100 + i, 1'b1, 0, 1'b0, "R1 fill");
    endtask

    task automatic t_latency();
        for (int i = 0; i < 24; i++) step((i * 37 + 5) % 1024, 1'b1, 0, 1'b0, "R2");
    endtask

    task automatic t_pedestal();
        for (int i = 0; i < 20; i++) step(i * 11, 1'b1, 8, 1'b0, "R3");
        for (int i = 0; i < 16; i++) step(300 + i, 1'b1, i, 1'b0, "R9");
        for (int i = 0; i < 10; i++) step(7, 1'b1, 15 - i, 1'b0, "R9");
    endtask

    task automatic t_saturate();
        step(1000, 1'b1, 15, 1'b0, "R4");
        step(963,  1'b1, 15, 1'b0, "R4");
        step(962,  1'b1, 15, 1'b0, "R4");
        step(1023, 1'b1, 0,  1'b0, "R4");
        step(1023, 1'b1, 1,  1'b0, "R4");
        step(1020, 1'b1, 1,  1'b0, "R4");
        step(1019, 1'b1, 1,  1'b0, "R4");
        for (int i = 0; i < 10; i++) step(50, 1'b1, 0, 1'b0, "R4");
    endtask

    task automatic t_onset_release();
        for (int i = 0; i < 25; i++) step(600 + i, 1'b0, 2, 1'b0, "R5");
        for (int i = 0; i < 20; i++) step(700 + i, 1'b1, 2, 1'b0, "R6");
    endtask

    task automatic t_pulse();
        step(400, 1'b0, 0, 1'b0, "R7");
        for (int i = 0; i < 15; i++) step(401 + i, 1'b1, 0, 1'b0, "R7");
        step(450, 1'b0, 0, 1'b0, "R7");
        step(451, 1'b0, 0, 1'b0, "R7");
        for (int i = 0; i < 15; i++) step(452 + i, 1'b1, 0, 1'b0, "R7");
    endtask

    task automatic t_standby();
        for (int i = 0; i < 12; i++) step(200 + i, 1'b1, 1, 1'b0, "R8");
        for (int i = 0; i < 6;  i++) step(220 + i, 1'b1, 1, 1'b1, "R8");
        for (int i = 0; i < 6;  i++) step(240 + i, 1'b0, 1, 1'b1, "R8");
        for (int i = 0; i < 20; i++) step(260 + i, 1'b1, 1, 1'b0, "R8");
    endtask

    task automatic t_random();
        bit pb;
        pb = 1'b1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) pb = ~pb;
            step(int'(lfsr[15:6]), pb, int'(lfsr[3:0]), (lfsr[9:4] == 6'd5), "R5/R6 random");
        end
        for (int i = 0; i < 14; i++) step(i, 1'b1, 0, 1'b0, "R6 drain");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_pedestal();
        t_saturate();
        t_onset_release();
        t_pulse();
        t_standby();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule